// File: doc/BRIEF.md
# Shared-Level Interrupt Pending Controller

This block keeps track of every interrupt waiting at one shared priority level inside an I/O port bridge. Two kinds of source feed the level. The first is a locally raised error interrupt, set by any of several error-detect inputs. The second is a set of interrupts forwarded from up to four remote nodes, which arrive over an upstream link. The block drives a single request line toward the system bus interrupt logic. It presents the vector of the interrupt that would be serviced next, and it clears that interrupt when the bus logic acknowledges it.

Software programs two items through a small write port: the vector that the local error interrupt supplies, and one enable bit. The enable bit gates every local error source as a group. Remote interrupts enter through a valid/ready stream that carries a slot number and a vector. The stream applies back-pressure per slot: `rmt_ready_o` is low while the addressed slot is still pending. A held beat waits until that slot has been acknowledged. The sender must keep slot and vector stable while valid is high and ready is low.

When a remote interrupt is acknowledged, the block raises a one-cycle strobe in the following cycle, naming the node, so that a status packet is sent back downstream. Acknowledging the local error interrupt never raises this strobe.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Reset leaves `irq_o` low, all remote slots free (`rmt_ready_o` high), `sts_req_o` low, the local enable bit at 0 and the local vector register at 0.
- R2: A cycle in which any bit of `err_src_i` is 1 sets the single local pending flag. The flag stays set until one acknowledge of the local interrupt, however many source bits fired.
- R3: While the local enable bit is 0, a pending local error does not drive `irq_o` and is not selected. Setting the bit later, with the flag still set, raises `irq_o`.
- R4: A remote beat is accepted when `rmt_valid_i` and `rmt_ready_o` are both high at a clock edge, storing `rmt_vec_i` into slot `rmt_slot_i`. `rmt_ready_o` is low exactly while the addressed slot is pending, and a refused beat changes nothing.
- R5: `irq_o` is high when any remote slot is pending, or when the local flag is pending and enabled.
- R6: Service order is the enabled local error first, then remote slots from 0 to 3 in that order.
- R7: `vec_o` shows the local vector register when the local error is selected, and otherwise the stored vector of the selected remote slot.
- R8: `ack_i` high at a clock edge while `irq_o` is high clears the selected interrupt. For a remote slot, `sts_req_o` is high for the next cycle only, with `sts_node_o` equal to the slot number. For the local error, `sts_req_o` stays low.
- R9: `ack_i` while `irq_o` is low has no effect and produces no `sts_req_o`.
- R10: A write with `cfg_we_i` high and `cfg_sel_i` = 0 loads `cfg_wdata_i` into the local vector register. With `cfg_sel_i` = 1, the write loads `cfg_wdata_i[0]` into the enable bit.
- R11: If an error source fires in the same cycle that the local interrupt is acknowledged, the local flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_src_i | input | N_SRC | Local error-detect inputs, any bit sets the local flag |
| rmt_valid_i | input | 1 | Remote interrupt beat valid |
| rmt_ready_o | output | 1 | Addressed remote slot is free |
| rmt_slot_i | input | SLOT_W | Remote node slot number |
| rmt_vec_i | input | VEC_W | Vector carried by the remote interrupt |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = local vector, 1 = enable bit |
| cfg_wdata_i | input | VEC_W | Configuration write data |
| irq_o | output | 1 | Interrupt request at the shared level |
| vec_o | output | VEC_W | Vector of the interrupt selected for service |
| ack_i | input | 1 | Acknowledge of the selected interrupt |
| sts_req_o | output | 1 | One-cycle request for a downstream status packet |
| sts_node_o | output | SLOT_W | Remote node the status packet belongs to |

## Verification
Every cycle, the assertions check the following:
- any error-source activity leaves the local flag set on the next cycle;
- an accepted remote beat holds `irq_o` high on the next cycle;
- `irq_o` is never high without an enabled local flag or a pending slot;
- an enabled local flag always wins selection;
- every status strobe follows a remote acknowledge;
- an idle acknowledge produces no strobe.

Only the bench scenarios can show that:
- the vectors come out in the exact service order;
- a refused beat leaves the stored vector untouched;
- the configuration writes land in the right register;
- the reset values are as stated;
- a local acknowledge that coincides with a new error leaves the request standing.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic {
    CFG_VECTOR = 1'b0,
    CFG_ENABLE = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pend_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] loc_vec,
  output logic             loc_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_vec <= '0;
      loc_en  <= 1'b0;
    end else if (we) begin
      if (cfg_sel_e'(sel) == CFG_VECTOR) loc_vec <= wdata;
      else                               loc_en  <= wdata[0];
    end
  end
endmodule

// File: rtl/irq_local_flag.sv
module irq_local_flag #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] err_src,
  input  logic             clr,
  output logic             pend
);
  logic any_err;
  assign any_err = |err_src;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~clr) | any_err;
  end
endmodule

// File: rtl/irq_remote_slots.sv
module irq_remote_slots #(
  parameter int N_RMT  = 4,
  parameter int VEC_W  = 16,
  parameter int SLOT_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [SLOT_W-1:0]           in_slot,
  input  logic [VEC_W-1:0]            in_vec,
  output logic                        in_ready,
  input  logic [N_RMT-1:0]            clr_mask,
  output logic [N_RMT-1:0]            pend,
  output logic [N_RMT-1:0][VEC_W-1:0] vecs
);
  logic in_take;
  assign in_ready = ~pend[in_slot];
  assign in_take  = in_valid & in_ready;

  for (genvar s = 0; s < N_RMT; s++) begin : g_slot
    logic hit;
    assign hit = in_take && (in_slot == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[s] <= 1'b0;
        vecs[s] <= '0;
      end else begin
        if (hit) begin
          pend[s] <= 1'b1;
          vecs[s] <= in_vec;
        end else if (clr_mask[s]) begin
          pend[s] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N_RMT  = 4,
  parameter int SLOT_W = 2
) (
  input  logic              loc_req,
  input  logic [N_RMT-1:0]  rmt_pend,
  output logic              any_req,
  output logic              win_local,
  output logic [SLOT_W-1:0] win_slot,
  output logic [N_RMT-1:0]  win_onehot
);
  always_comb begin
    win_slot = '0;
    for (int i = N_RMT - 1; i >= 0; i--) begin
      if (rmt_pend[i]) win_slot = SLOT_W'(i);
    end
  end

  assign win_local = loc_req;
  assign any_req   = loc_req | (|rmt_pend);

  for (genvar s = 0; s < N_RMT; s++) begin : g_oh
    assign win_onehot[s] = ~loc_req & rmt_pend[s] & (win_slot == SLOT_W'(s));
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int N_RMT  = 4,
  parameter int N_SRC  = 4,
  parameter int VEC_W  = 16,
  parameter int SLOT_W = (N_RMT > 1) ? $clog2(N_RMT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  err_src_i,
  input  logic              rmt_valid_i,
  output logic              rmt_ready_o,
  input  logic [SLOT_W-1:0] rmt_slot_i,
  input  logic [VEC_W-1:0]  rmt_vec_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [VEC_W-1:0]  cfg_wdata_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              ack_i,
  output logic              sts_req_o,
  output logic [SLOT_W-1:0] sts_node_o
);
  logic                        loc_vec_en;
  logic [VEC_W-1:0]            loc_vec;
  logic                        loc_en;
  logic                        loc_pend;
  logic [N_RMT-1:0]            rmt_pend;
  logic [N_RMT-1:0][VEC_W-1:0] rmt_vecs;
  logic                        any_req;
  logic                        win_local;
  logic [SLOT_W-1:0]           win_slot;
  logic [N_RMT-1:0]            win_onehot;
  logic                        ack_take;

  assign loc_vec_en = loc_pend & loc_en;
  assign ack_take   = ack_i & any_req;

  irq_cfg_regs #(.VEC_W(VEC_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we_i),
    .sel     (cfg_sel_i),
    .wdata   (cfg_wdata_i),
    .loc_vec (loc_vec),
    .loc_en  (loc_en)
  );

  irq_local_flag #(.N_SRC(N_SRC)) u_loc (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_src (err_src_i),
    .clr     (ack_take & win_local),
    .pend    (loc_pend)
  );

  irq_remote_slots #(.N_RMT(N_RMT), .VEC_W(VEC_W), .SLOT_W(SLOT_W)) u_rmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rmt_valid_i),
    .in_slot  (rmt_slot_i),
    .in_vec   (rmt_vec_i),
    .in_ready (rmt_ready_o),
    .clr_mask (win_onehot & {N_RMT{ack_take}}),
    .pend     (rmt_pend),
    .vecs     (rmt_vecs)
  );

  irq_prio_sel #(.N_RMT(N_RMT), .SLOT_W(SLOT_W)) u_sel (
    .loc_req    (loc_vec_en),
    .rmt_pend   (rmt_pend),
    .any_req    (any_req),
    .win_local  (win_local),
    .win_slot   (win_slot),
    .win_onehot (win_onehot)
  );

  assign irq_o = any_req;
  assign vec_o = win_local ? loc_vec : rmt_vecs[win_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_req_o  <= 1'b0;
      sts_node_o <= '0;
    end else begin
      sts_req_o  <= ack_take & ~win_local;
      sts_node_o <= win_slot;
    end
  end
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int N_RMT = 4,
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] err_src_i,
  input logic             rmt_valid_i,
  input logic             rmt_ready_o,
  input logic             ack_i,
  input logic             irq_o,
  input logic             sts_req_o,
  input logic             loc_pend,
  input logic             loc_en,
  input logic [N_RMT-1:0] rmt_pend,
  input logic             win_local
);
  // R2
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_src_i) |=> loc_pend);

  // R4
  rmt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmt_valid_i && rmt_ready_o) |=> irq_o);

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((|rmt_pend) || (loc_pend && loc_en)));

  // R6
  local_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_pend && loc_en) |-> win_local);

  // R8
  sts_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_req_o |-> $past(ack_i && irq_o && !win_local));

  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o) |=> !sts_req_o);
endmodule

bind irq_pend_ctrl irq_pend_chk #(.N_RMT(N_RMT), .N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_src_i   (err_src_i),
  .rmt_valid_i (rmt_valid_i),
  .rmt_ready_o (rmt_ready_o),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .sts_req_o   (sts_req_o),
  .loc_pend    (loc_pend),
  .loc_en      (loc_en),
  .rmt_pend    (rmt_pend),
  .win_local   (win_local)
);

// File: tb/irq_pend_ctrl_tb_top.sv
module irq_pend_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  err_src_i = '0;
  logic        rmt_valid_i = 1'b0;
  logic        rmt_ready_o;
  logic [1:0]  rmt_slot_i = '0;
  logic [15:0] rmt_vec_i = '0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        irq_o;
  logic [15:0] vec_o;
  logic        ack_i = 1'b0;
  logic        sts_req_o;
  logic [1:0]  sts_node_o;

  always #4 clk = ~clk;

  irq_pend_ctrl dut_i (.*);

  typedef struct {
    logic [15:0] vec;
    bit          rmt;
    int          node;
  } exp_t;

  exp_t exp_q[$];
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  // reference model state
  bit          m_loc = 0;
  bit          m_en = 0;
  logic [15:0] m_lvec = '0;
  bit          m_rp [4] = '{0, 0, 0, 0};
  logic [15:0] m_rv [4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_irq();
    bit r = m_loc && m_en;
    for (int i = 0; i < 4; i++) r |= m_rp[i];
    return r;
  endfunction

  task automatic chk_irq(input string req);
    @(negedge clk);
    chk(irq_o == m_irq(), req, irq_o, m_irq());
  endtask

  task automatic cfg_write(input bit sel, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(posedge clk); #1;
    cfg_we_i = 0;
    if (sel) m_en = d[0];
    else     m_lvec = d;
  endtask

  task automatic fire_err(input logic [3:0] bits);
    @(posedge clk); #1;
    err_src_i = bits;
    @(posedge clk); #1;
    err_src_i = '0;
    m_loc = 1;
  endtask

  task automatic send(input int slot, input logic [15:0] v);
    bit acc;
    @(posedge clk); #1;
    rmt_valid_i = 1; rmt_slot_i = 2'(slot); rmt_vec_i = v;
    @(negedge clk);
    acc = !m_rp[slot];
    chk(rmt_ready_o == acc, "R4 ready", rmt_ready_o, acc);
    @(posedge clk); #1;
    rmt_valid_i = 0;
    if (acc) begin
      m_rp[slot] = 1;
      m_rv[slot] = v;
    end
  endtask

  // driver: computes the expected service item and pushes it into the scoreboard
  task automatic do_ack(input bit with_err);
    exp_t e;
    @(posedge clk); #1;
    if (m_irq()) begin
      if (m_loc && m_en) begin
        e.vec = m_lvec; e.rmt = 0; e.node = 0; m_loc = 0;
      end else begin
        e.rmt = 1;
        for (int i = 3; i >= 0; i--) if (m_rp[i]) e.node = i;
        e.vec = m_rv[e.node];
        m_rp[e.node] = 0;
      end
      exp_q.push_back(e);
    end
    ack_i = 1;
    if (with_err) err_src_i = 4'b1000;
    @(posedge clk); #1;
    ack_i = 0; err_src_i = '0;
    if (with_err) m_loc = 1;
  endtask

  // monitor: pops expected items as acknowledges are taken
  bit   wait_sts = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wait_sts) begin
        chk(sts_req_o == cur.rmt, "R8 sts strobe", sts_req_o, cur.rmt);
        if (cur.rmt) chk(sts_node_o == 2'(cur.node), "R8 sts node", sts_node_o, cur.node);
        wait_sts = 0;
      end else begin
        chk(!sts_req_o, "R8 R9 unexpected sts", sts_req_o, 0);
      end
      if (ack_i && irq_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected ack service", vec_o, 0);
        end else begin
          cur = exp_q.pop_front();
          chk(vec_o == cur.vec, "R6 R7 vector", vec_o, cur.vec);
          wait_sts = 1;
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    chk(rmt_ready_o == 1, "R1 ready", rmt_ready_o, 1);
    chk(sts_req_o == 0, "R1 sts", sts_req_o, 0);
    // R1 enable reset to 0: error alone raises nothing
    fire_err(4'b0001);
    chk_irq("R1 R3 masked after reset");
    // R10 enable write; R1 vector is zero
    cfg_write(1'b1, 16'h0001);
    chk_irq("R10 R3 enable raises irq");
    do_ack(0);
    chk_irq("R8 local cleared");
    // R10 vector write, R2 several sources give one pending
    cfg_write(1'b0, 16'hA5C3);
    cfg_write(1'b1, 16'h0000);
    fire_err(4'b0110);
    chk_irq("R3 masked");
    cfg_write(1'b1, 16'h0001);
    chk_irq("R3 enable later");
    do_ack(0);
    chk_irq("R2 single ack clears");
    // R4 remote beats and back-pressure
    send(2, 16'h1202);
    send(0, 16'h1000);
    send(3, 16'h1303);
    send(2, 16'hDEAD);
    chk_irq("R5 remote pending");
    fire_err(4'b0100);
    // R6 order: local, slot0, slot2, slot3
    do_ack(0);
    do_ack(0);
    do_ack(0);
    do_ack(0);
    chk_irq("R6 all serviced");
    chk(rmt_ready_o == 1, "R4 slot free again", rmt_ready_o, 1);
    // R9 idle acknowledge
    do_ack(0);
    @(negedge clk);
    chk(sts_req_o == 0, "R9 idle ack", sts_req_o, 0);
    chk(irq_o == 0, "R9 idle irq", irq_o, 0);
    // R11 new error coinciding with local acknowledge
    fire_err(4'b0001);
    do_ack(1);
    chk_irq("R11 stays pending");
    do_ack(0);
    chk_irq("R11 cleared");
    // R3 masked local skipped in favour of remote
    cfg_write(1'b1, 16'h0000);
    fire_err(4'b0010);
    send(1, 16'h1101);
    do_ack(0);
    chk_irq("R3 masked local left");
    cfg_write(1'b1, 16'h0001);
    chk_irq("R3 re-enabled");
    do_ack(0);
    chk_irq("R5 idle at end");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule